// File: doc/BRIEF.md
# DMA Descriptor Chain Fetcher

This block walks a linked list of transfer descriptors stored in system memory and loads each one into a DMA channel's working registers. Every descriptor is four 32-bit words read in a fixed order: length, control, start address, next pointer. The block reads them over a read-only WISHBONE master port. After the fourth word it starts the transfer engine through a one-cycle start pulse and waits for the engine's done pulse. It then either fetches the next descriptor or stops, depending on the chain bit in the control word it just loaded.

The host sets the first descriptor's address in the pointer register, then writes the control register with the chain bit set. Host writes to either register take effect only while the fetcher is idle. Every bus request holds `cyc` and `stb` steady, with a stable address, until the memory answers. The memory applies back-pressure by withholding `ack`, so each word costs at least one cycle plus any wait states. A bus error stops the walk and latches an error status. The fetcher then does nothing more until the host writes the control register again.

Control bit assignments used by the fetcher: bit 0 is chain/fetch enable, bit 1 is error status, and bit 2 is transfer-done status. All other control bits pass through unchanged to the engine.

Top module: `dma_desc_fetcher`

## Requirements
- R1: After reset the state code is 0 (idle), `wb_cyc_o`, `wb_stb_o` and `eng_start_o` are low, and the length, control, address and pointer registers are all zero.
- R2: A walk starts from the idle state only when control bit 0 (fetch) is 1 and control bit 1 (error) is 0. It reads from the address held in the pointer register. With bit 0 clear, or with bit 1 set, no bus request is made.
- R3: Word n of a descriptor (n = 0..3) is requested at pointer + 4·n. `wb_cyc_o`/`wb_stb_o` stay high with an unchanged address until `wb_ack_i` or `wb_err_i` arrives.
- R4: The state code follows 1 (length) → 2 (control) → 3 (address) → 4 (next) and advances only on `wb_ack_i`. A three-descriptor chain produces exactly twelve accepted reads, in order.
- R5: Word 0 loads the low 12 bits into the length register. Word 1 loads the low 9 bits into the control register. Word 2 loads the start address. Word 3 loads the pointer register.
- R6: `eng_start_o` pulses for one cycle, in the cycle after the word-3 ack. The state code is then 5 (running), and no bus request is made until `eng_done_i`.
- R7: On `eng_done_i` in state 5, control bit 2 is set. If control bit 0 of the loaded control word is 1, fetching restarts at state 1 from the new pointer. Otherwise the block returns to idle and makes no further requests.
- R8: `wb_err_i` during a fetch sets control bit 1, returns to idle with the bus released, and produces no engine start. Fetching resumes only after the host rewrites the control register.
- R9: Host writes to the pointer or control register while the state code is not 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ptr_we | input | 1 | Host write strobe for the pointer register |
| host_ptr_wdata | input | 32 | Pointer value written by the host |
| host_ctrl_we | input | 1 | Host write strobe for the control register |
| host_ctrl_wdata | input | 9 | Control value written by the host |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus strobe, read request valid |
| wb_adr_o | output | 32 | Byte address of the requested word |
| wb_dat_i | input | 32 | Read data, valid with ack |
| wb_ack_i | input | 1 | Read accepted (ready) |
| wb_err_i | input | 1 | Bus error terminating the request |
| eng_start_o | output | 1 | One-cycle start pulse to the transfer engine |
| eng_done_i | input | 1 | One-cycle completion pulse from the engine |
| xfer_len_o | output | 12 | Transfer length register |
| xfer_ctrl_o | output | 9 | Control register |
| xfer_addr_o | output | 32 | Transfer start address register |
| desc_ptr_o | output | 32 | Descriptor pointer register |
| fetch_state_o | output | 3 | Current state code |

## Verification
The hardest cases to reach are a host write that arrives while the engine is running, and a bus error in the middle of a descriptor after an earlier descriptor has already completed. The bench handles the first by watching for the second engine start and then driving both host write strobes during the run window. It handles the second by having its memory model answer one chosen address with an error instead of an ack. The chain walk is repeated across a sweep of memory wait states, so the hold-until-ack rule is exercised with 0 to 3 stalled cycles per word.

// File: rtl/dma_fetch_pkg.sv
package dma_fetch_pkg;
  typedef enum logic [2:0] {
    FS_IDLE = 3'd0,
    FS_LEN  = 3'd1,
    FS_CTL  = 3'd2,
    FS_ADR  = 3'd3,
    FS_NXT  = 3'd4,
    FS_RUN  = 3'd5
  } fetch_state_e;

  localparam int unsigned WORDS_PER_DESC = 4;
  localparam int unsigned IDX_W = $clog2(WORDS_PER_DESC);
endpackage

// File: rtl/dma_fetch_fsm.sv
module dma_fetch_fsm
  import dma_fetch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             chain_on,
  input  logic             bus_ack,
  input  logic             bus_err,
  input  logic             eng_done,
  output fetch_state_e     state,
  output logic [IDX_W-1:0] word_idx,
  output logic             req,
  output logic             load_en,
  output logic             abort,
  output logic             done_evt,
  output logic             eng_start
);
  fetch_state_e state_n;

  always_comb begin
    req = (state == FS_LEN) || (state == FS_CTL) ||
          (state == FS_ADR) || (state == FS_NXT);
    unique case (state)
      FS_CTL:  word_idx = IDX_W'(1);
      FS_ADR:  word_idx = IDX_W'(2);
      FS_NXT:  word_idx = IDX_W'(3);
      default: word_idx = IDX_W'(0);
    endcase
    abort    = req && bus_err;
    load_en  = req && bus_ack && !bus_err;
    done_evt = (state == FS_RUN) && eng_done;
  end

  always_comb begin
    state_n = state;
    unique case (state)
      FS_IDLE: if (go) state_n = FS_LEN;
      FS_LEN:  if (abort) state_n = FS_IDLE; else if (load_en) state_n = FS_CTL;
      FS_CTL:  if (abort) state_n = FS_IDLE; else if (load_en) state_n = FS_ADR;
      FS_ADR:  if (abort) state_n = FS_IDLE; else if (load_en) state_n = FS_NXT;
      FS_NXT:  if (abort) state_n = FS_IDLE; else if (load_en) state_n = FS_RUN;
      FS_RUN:  if (eng_done) state_n = chain_on ? FS_LEN : FS_IDLE;
      default: state_n = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= FS_IDLE;
      eng_start <= 1'b0;
    end else begin
      state     <= state_n;
      eng_start <= (state == FS_NXT) && load_en;
    end
  end
endmodule

// File: rtl/dma_fetch_addr.sv
module dma_fetch_addr
  import dma_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  word_idx,
  output logic [ADDR_W-1:0] adr
);
  localparam int unsigned BYTES = DATA_W / 8;
  localparam int unsigned SHIFT = $clog2(BYTES);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = ADDR_W'(word_idx) << SHIFT;
    adr    = base + offset;
  end
endmodule

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
  import dma_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LEN_W    = 12,
  parameter int unsigned CTRL_W   = 9,
  parameter int unsigned ERR_BIT  = 1,
  parameter int unsigned DONE_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              host_ptr_we,
  input  logic [ADDR_W-1:0] host_ptr_wdata,
  input  logic              host_ctrl_we,
  input  logic [CTRL_W-1:0] host_ctrl_wdata,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              abort,
  input  logic              done_evt,
  output logic [LEN_W-1:0]  len_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] ptr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      ctrl_q <= '0;
      addr_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (idle && host_ptr_we)  ptr_q  <= host_ptr_wdata;
      if (idle && host_ctrl_we) ctrl_q <= host_ctrl_wdata;
      if (load_en) begin
        unique case (word_idx)
          IDX_W'(0): len_q  <= rd_data[LEN_W-1:0];
          IDX_W'(1): ctrl_q <= rd_data[CTRL_W-1:0];
          IDX_W'(2): addr_q <= rd_data[ADDR_W-1:0];
          default:   ptr_q  <= rd_data[ADDR_W-1:0];
        endcase
      end
      if (abort)    ctrl_q[ERR_BIT]  <= 1'b1;
      if (done_evt) ctrl_q[DONE_BIT] <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_desc_fetcher.sv
module dma_desc_fetcher
  import dma_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned CTRL_W    = 9,
  parameter int unsigned FETCH_BIT = 0,
  parameter int unsigned ERR_BIT   = 1,
  parameter int unsigned DONE_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_ptr_we,
  input  logic [ADDR_W-1:0] host_ptr_wdata,
  input  logic              host_ctrl_we,
  input  logic [CTRL_W-1:0] host_ctrl_wdata,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  input  logic [DATA_W-1:0] wb_dat_i,
  input  logic              wb_ack_i,
  input  logic              wb_err_i,
  output logic              eng_start_o,
  input  logic              eng_done_i,
  output logic [LEN_W-1:0]  xfer_len_o,
  output logic [CTRL_W-1:0] xfer_ctrl_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic [ADDR_W-1:0] desc_ptr_o,
  output logic [2:0]        fetch_state_o
);
  fetch_state_e     state;
  logic [IDX_W-1:0] word_idx;
  logic             req, load_en, abort, done_evt, go, idle;

  assign idle = (state == FS_IDLE);
  assign go   = xfer_ctrl_o[FETCH_BIT] && !xfer_ctrl_o[ERR_BIT];

  dma_fetch_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .chain_on (xfer_ctrl_o[FETCH_BIT]),
    .bus_ack  (wb_ack_i),
    .bus_err  (wb_err_i),
    .eng_done (eng_done_i),
    .state    (state),
    .word_idx (word_idx),
    .req      (req),
    .load_en  (load_en),
    .abort    (abort),
    .done_evt (done_evt),
    .eng_start(eng_start_o)
  );

  dma_fetch_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .base    (desc_ptr_o),
    .word_idx(word_idx),
    .adr     (wb_adr_o)
  );

  dma_desc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .CTRL_W(CTRL_W),
    .ERR_BIT(ERR_BIT), .DONE_BIT(DONE_BIT)
  ) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .idle           (idle),
    .host_ptr_we    (host_ptr_we),
    .host_ptr_wdata (host_ptr_wdata),
    .host_ctrl_we   (host_ctrl_we),
    .host_ctrl_wdata(host_ctrl_wdata),
    .load_en        (load_en),
    .word_idx       (word_idx),
    .rd_data        (wb_dat_i),
    .abort          (abort),
    .done_evt       (done_evt),
    .len_q          (xfer_len_o),
    .ctrl_q         (xfer_ctrl_o),
    .addr_q         (xfer_addr_o),
    .ptr_q          (desc_ptr_o)
  );

  assign wb_cyc_o      = req;
  assign wb_stb_o      = req;
  assign fetch_state_o = state;
endmodule

// File: rtl/dma_desc_fetcher_chk.sv
module dma_desc_fetcher_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CTRL_W  = 9,
  parameter int unsigned ERR_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wb_stb_o,
  input logic              wb_cyc_o,
  input logic [ADDR_W-1:0] wb_adr_o,
  input logic              wb_ack_i,
  input logic              wb_err_i,
  input logic              eng_start_o,
  input logic              eng_done_i,
  input logic [CTRL_W-1:0] xfer_ctrl_o,
  input logic [2:0]        fetch_state_o
);
  // R3: a pending request keeps its address until answered
  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb_o && !wb_ack_i && !wb_err_i) |=> (wb_stb_o && $stable(wb_adr_o)));

  // R4: each accepted word moves to the next fetch state
  a_r4_step_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb_o && wb_ack_i && !wb_err_i) |=> (fetch_state_o == $past(fetch_state_o) + 3'd1));

  // R6: engine start follows the final descriptor word
  a_r6_start_after_next: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> (fetch_state_o == 3'd5 && $past(fetch_state_o) == 3'd4 && !wb_cyc_o));

  // R6: no bus activity while the engine owns the channel
  a_r6_quiet_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_state_o == 3'd5 && !eng_done_i) |=> !wb_cyc_o);

  // R8: a bus error releases the bus and flags the error
  a_r8_error_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && wb_err_i) |=> (fetch_state_o == 3'd0 && xfer_ctrl_o[ERR_BIT] && !eng_start_o));
endmodule

bind dma_desc_fetcher dma_desc_fetcher_chk #(
  .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .ERR_BIT(ERR_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wb_stb_o     (wb_stb_o),
  .wb_cyc_o     (wb_cyc_o),
  .wb_adr_o     (wb_adr_o),
  .wb_ack_i     (wb_ack_i),
  .wb_err_i     (wb_err_i),
  .eng_start_o  (eng_start_o),
  .eng_done_i   (eng_done_i),
  .xfer_ctrl_o  (xfer_ctrl_o),
  .fetch_state_o(fetch_state_o)
);

// File: tb/dma_desc_fetcher_bench.sv
module dma_desc_fetcher_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        host_ptr_we = 1'b0, host_ctrl_we = 1'b0;
  logic [31:0] host_ptr_wdata = '0;
  logic [8:0]  host_ctrl_wdata = '0;
  logic        wb_cyc_o, wb_stb_o, wb_ack_i, wb_err_i;
  logic [31:0] wb_adr_o, wb_dat_i;
  logic        eng_start_o, eng_done_i;
  logic [11:0] xfer_len_o;
  logic [8:0]  xfer_ctrl_o;
  logic [31:0] xfer_addr_o, desc_ptr_o;
  logic [2:0]  fetch_state_o;

  dma_desc_fetcher u_dma_desc_fetcher (.*);

  int checks = 0, fails = 0, cycles = 0;
  int wait_n = 0, wcnt = 0, ecnt = 0;
  logic [31:0] err_adr = 32'hFFFF_FFFF;
  logic [31:0] mem [0:255];

  // memory model: registered ack/err after wait_n stalled cycles
  always @(posedge clk) begin
    if (!rst_n) begin wb_ack_i <= 0; wb_err_i <= 0; wcnt <= 0; end
    else if (wb_cyc_o && wb_stb_o && !wb_ack_i && !wb_err_i) begin
      if (wcnt >= wait_n) begin
        wcnt <= 0;
        if (wb_adr_o == err_adr) wb_err_i <= 1; else wb_ack_i <= 1;
      end else wcnt <= wcnt + 1;
    end else begin wb_ack_i <= 0; wb_err_i <= 0; end
  end
  assign wb_dat_i = mem[wb_adr_o[9:2]];

  // engine model: done three cycles after start
  always @(posedge clk) begin
    if (!rst_n) begin ecnt <= 0; eng_done_i <= 0; end
    else begin
      eng_done_i <= 1'b0;
      if (eng_start_o) ecnt <= 3;
      else if (ecnt > 0) begin ecnt <= ecnt - 1; if (ecnt == 1) eng_done_i <= 1'b1; end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] dbase(input int k);
    return (k == 0) ? 32'h100 : (k == 1) ? 32'h200 : 32'h180;
  endfunction
  function automatic logic [31:0] dlen(input int k, input int w);
    return 32'(10 + 5 * k + w);
  endfunction
  function automatic logic [31:0] dctl(input int k);
    return ((k < 2) ? 32'h1 : 32'h0) | 32'((k + 1) << 4);
  endfunction
  function automatic logic [31:0] dadr(input int k, input int w);
    return 32'h4000_0000 + 32'(k) * 32'h100 + 32'(w);
  endfunction

  task automatic fill(input int w);
    for (int k = 0; k < 3; k++) begin
      mem[dbase(k) >> 2]       = 32'hABC0_0000 | dlen(k, w);
      mem[(dbase(k) >> 2) + 1] = 32'h5500_0000 | dctl(k);
      mem[(dbase(k) >> 2) + 2] = dadr(k, w);
      mem[(dbase(k) >> 2) + 3] = (k < 2) ? dbase(k + 1) : 32'h0000_0EE0;
    end
  endtask

  task automatic host_load(input logic [31:0] p, input logic [8:0] c);
    @(negedge clk); host_ptr_we = 1; host_ptr_wdata = p;
    @(negedge clk); host_ptr_we = 0; host_ctrl_we = 1; host_ctrl_wdata = c;
    @(negedge clk); host_ctrl_we = 0;
  endtask

  task automatic run_chain(input int w);
    int fi = 0, k = 0, inj = 0;
    wait_n = w; err_adr = 32'hFFFF_FFFF; fill(w);
    host_load(32'h100, 9'h001);
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (inj == 1) begin
        host_ptr_we = 0; host_ctrl_we = 0; inj = 2;
        chk("R9", "ptr after busy write", desc_ptr_o, dbase(2));
        chk("R9", "ctrl after busy write", 32'(xfer_ctrl_o), dctl(1));
      end
      if (wb_ack_i) begin
        chk("R3", "fetch address", wb_adr_o, dbase(fi / 4) + 32'((fi % 4) * 4));
        chk("R4", "state at ack", 32'(fetch_state_o), 32'(fi % 4 + 1));
        fi++;
      end
      if (eng_start_o) begin
        chk("R6", "state at start", 32'(fetch_state_o), 32'd5);
        chk("R5", "length", 32'(xfer_len_o), dlen(k, w));
        chk("R5", "control", 32'(xfer_ctrl_o), dctl(k));
        chk("R5", "address", xfer_addr_o, dadr(k, w));
        chk("R5", "pointer", desc_ptr_o, (k < 2) ? dbase(k + 1) : 32'h0EE0);
        if (k == 1) begin
          host_ptr_we = 1; host_ptr_wdata = 32'h3F0;
          host_ctrl_we = 1; host_ctrl_wdata = 9'h000; inj = 1;
        end
        k++;
      end
      if (k == 3 && fetch_state_o == 3'd0) break;
    end
    chk("R4", "reads in chain", 32'(fi), 32'd12);
    chk("R7", "final control with done", 32'(xfer_ctrl_o), dctl(2) | 32'h4);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (wb_cyc_o) break;
    end
    chk("R7", "bus idle after chain end", 32'(wb_cyc_o), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'(i) * 32'h0101_0101;
    repeat (4) @(negedge clk);
    chk("R1", "reset state", 32'(fetch_state_o), 32'd0);
    chk("R1", "reset cyc", 32'(wb_cyc_o), 32'd0);
    chk("R1", "reset start", 32'(eng_start_o), 32'd0);
    chk("R1", "reset regs", desc_ptr_o | xfer_addr_o | 32'(xfer_ctrl_o) | 32'(xfer_len_o), 32'd0);
    rst_n = 1'b1;

    // fetch bit clear, then fetch with error bit set: neither may fetch
    host_load(32'h100, 9'h0F0);
    repeat (10) @(negedge clk);
    chk("R2", "no fetch with bit 0 clear", 32'(wb_cyc_o) | 32'(fetch_state_o), 32'd0);
    host_load(32'h100, 9'h003);
    repeat (10) @(negedge clk);
    chk("R2", "no fetch with error bit set", 32'(wb_cyc_o) | 32'(fetch_state_o), 32'd0);

    for (int w = 0; w < 4; w++) run_chain(w);

    // bus error on the control word of the second descriptor
    begin
      int starts = 0, acks = 0, seen = 0;
      wait_n = 1; fill(7); err_adr = 32'h204;
      host_load(32'h100, 9'h001);
      for (int c = 0; c < 2000 && seen == 0; c++) begin
        @(negedge clk);
        if (eng_start_o) starts++;
        if (wb_ack_i) acks++;
        if (wb_err_i) seen = 1;
      end
      @(negedge clk);
      chk("R8", "state after error", 32'(fetch_state_o), 32'd0);
      chk("R8", "bus released", 32'(wb_cyc_o), 32'd0);
      chk("R8", "error bit", 32'(xfer_ctrl_o[1]), 32'd1);
      chk("R8", "engine starts", 32'(starts), 32'd1);
      chk("R8", "reads before error", 32'(acks), 32'd5);
      chk("R8", "pointer kept", desc_ptr_o, 32'h200);
      repeat (20) @(negedge clk);
      chk("R8", "no restart while error set", 32'(wb_cyc_o) | 32'(fetch_state_o), 32'd0);
      err_adr = 32'hFFFF_FFFF;
      host_load(32'h200, 9'h001);
      seen = 0;
      for (int c = 0; c < 2000 && seen == 0; c++) begin
        @(negedge clk);
        if (eng_start_o) seen = 1;
      end
      chk("R8", "length after recovery", 32'(xfer_len_o), dlen(1, 7));
      for (int c = 0; c < 2000 && fetch_state_o != 3'd0; c++) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule